// File: doc/BRIEF.md
# Dual-Mode Parallel Host Bus Slave

This block lets an 8-bit CPU read and write the register file of a peripheral controller over a parallel bus. A static mode input selects the bus style. In multiplexed mode the shared data bus first carries the low address byte, which an address-latch strobe captures. The separate address input then supplies the high byte, so the register window sits at 0x8000 to 0x804C. In separate mode the address input carries the low byte and the window sits at 0x00 to 0x4C.

Chip select, write strobe, read strobe and address-latch strobe are asynchronous to the block clock, so each passes through a two-flop synchronizer. A write is committed when the synchronized write strobe rises. The data bus is modelled as an output value plus an output enable. An interrupt request from the controller pulls the active-low interrupt line down. The line stays low until the CPU writes the clear bit in the control register at offset 0x03. The whole register image is exported flat to the controller logic.

Top module: `hbus_slave`

## Requirements
- R1: After a synchronous reset with rst_n low, int_n is 1, every register reads 0 and reg_image is all zero.
- R2: With bus_mode=1, a write with cs high and wr_n pulsed low stores data_in at the offset given by addr_in, and a later read of that offset returns it on data_out.
- R3: With bus_mode=0, an access reaches offset L only when addr_in equals 0x80 and L is the low byte captured from data_in while ale was high.
- R4: With bus_mode=0, the captured low address holds after ale falls, so later changes on data_in do not move the accessed register.
- R5: A write strobe while cs is low changes no register.
- R6: An access outside the window (offset above 0x4C, or in mode 0 a high byte other than 0x80) changes no register, and a read there returns 0.
- R7: data_oe is 1 exactly while cs is 1 and rd_n is 0.
- R8: The window edges, offsets 0x00 and 0x4C, are both writable and readable.
- R9: A one-cycle irq_req pulse drives int_n low from the next cycle on. int_n stays low until a write to offset 0x03 with bit 5 set is committed, and a write to 0x03 with bit 5 clear leaves it low.
- R10: Bit 5 of the register at offset 0x03 is an action bit: it always reads back 0, while the other seven bits of that register store the written value.
- R11: reg_image bits [8k+7:8k] equal the register at offset k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_mode | input | 1 | 0: multiplexed low address on data bus; 1: separate address bus |
| cs | input | 1 | Chip select, active high |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| ale | input | 1 | Address-latch strobe (mode 0) |
| addr_in | input | 8 | High address byte in mode 0, low address byte in mode 1 |
| data_in | input | 8 | Incoming side of the bidirectional data bus |
| data_out | output | 8 | Outgoing side of the data bus |
| data_oe | output | 1 | Enable for data_out onto the bus |
| irq_req | input | 1 | One-cycle interrupt request from the controller |
| int_n | output | 1 | Interrupt line, active low, held until cleared |
| reg_image | output | 616 | All registers, byte k at bits [8k+7:8k] |

## Verification
The hardest case to reach is R4 in mode 0: the low byte must come from the shared data bus while the latch strobe is high and must hold afterwards. The bench drives a full address phase for every mode-0 access. It then puts a different, in-window value on data_in before the strobes, so a latch that follows the bus reaches the wrong register. The interrupt line is compared with a reference flag on every clock. A clear write with bit 5 low comes before the real clear.

// File: rtl/hbus_pkg.sv
// Shared constants for the host bus slave.
// Assumes byte-wide registers; the interrupt-clear action bit's position is fixed here.
package hbus_pkg;
    parameter int unsigned BYTE_W    = 8;
    parameter int unsigned CLR_OFF   = 3;   // control register holding the clear bit
    parameter int unsigned CLR_BIT   = 5;   // action bit that releases the interrupt
    parameter int unsigned SYNC_DEPTH = 2;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/hbus_sync.sv
// Multi-bit flop-chain synchronizer with a per-bit reset value.
// Assumes each bit is an independent level; no bus coherency is implied.
module hbus_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // shift one stage of the chain per clock
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[s] <= RST_VAL;
                else if (s == 0)
                    chain[s] <= d;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hbus_decode.sv
// Address window decoder for both bus styles.
// Mode 0: window hit needs high byte == HI_WIN and low byte below REG_COUNT.
// Mode 1: window hit needs the address byte below REG_COUNT. Purely combinational.
module hbus_decode #(
    parameter int unsigned REG_COUNT = 77,
    parameter logic [7:0]  HI_WIN    = 8'h80,
    localparam int unsigned OFF_W    = $clog2(REG_COUNT)
) (
    input  logic             mode_sep,
    input  logic [7:0]       addr_byte,
    input  logic [7:0]       lo_latched,
    output logic             hit,
    output logic [OFF_W-1:0] off
);
    logic [7:0] low;

    // choose the low address source, then test the window
    always_comb begin
        low = mode_sep ? addr_byte : lo_latched;
        off = low[OFF_W-1:0];
        if (mode_sep)
            hit = (int'(low) < REG_COUNT);
        else
            hit = (addr_byte == HI_WIN) && (int'(low) < REG_COUNT);
    end
endmodule

// File: rtl/hbus_regfile.sv
// Register storage, registered read port and held interrupt flag.
// Assumes one committed write per cycle at most; a request pulse wins over a clear.
module hbus_regfile
    import hbus_pkg::*;
#(
    parameter int unsigned REG_COUNT = 77,
    localparam int unsigned OFF_W    = $clog2(REG_COUNT)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [OFF_W-1:0]             waddr,
    input  byte_t                        wdata,
    input  logic                         rd_hit,
    input  logic [OFF_W-1:0]             raddr,
    input  logic                         irq_req,
    output byte_t                        rdata,
    output logic                         int_n,
    output logic [REG_COUNT*BYTE_W-1:0]  image
);
    logic [REG_COUNT-1:0][BYTE_W-1:0] store;
    logic pend;
    logic clr_hit;

    assign clr_hit = we && (waddr == OFF_W'(CLR_OFF)) && wdata[CLR_BIT];

    // commit a write; the action bit of the control register is never stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store <= '0;
        end else if (we) begin
            for (int k = 0; k < REG_COUNT; k++) begin
                if (waddr == OFF_W'(k)) begin
                    if (k == CLR_OFF)
                        store[k] <= wdata & ~(BYTE_W'(1) << CLR_BIT);
                    else
                        store[k] <= wdata;
                end
            end
        end
    end

    // register the read value, zero outside the window
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else
            rdata <= rd_hit ? store[raddr] : '0;
    end

    // hold the interrupt until software clears it
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (irq_req)
            pend <= 1'b1;
        else if (clr_hit)
            pend <= 1'b0;
    end

    assign int_n = ~pend;
    assign image = store;

    assert_rst_release_R1: assert property (@(posedge clk) !rst_n |=> int_n);
    assert_irq_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> !int_n);
    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_n && !(we && waddr == OFF_W'(CLR_OFF) && wdata[CLR_BIT])) |=> !int_n);
    assert_store_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(store));
    assert_clr_bit_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        store[CLR_OFF][CLR_BIT] == 1'b0);
endmodule

// File: rtl/hbus_slave.sv
// Top of the host bus slave: synchronizes strobes, latches the mode-0 low
// address, captures write data while the strobe is low, commits on its rise.
// Assumes address and data are stable while their strobe is asserted and for
// a few clocks after it is released; bus_mode is static.
module hbus_slave
    import hbus_pkg::*;
#(
    parameter int unsigned REG_COUNT = 77,
    parameter logic [7:0]  HI_WIN    = 8'h80,
    localparam int unsigned OFF_W    = $clog2(REG_COUNT),
    localparam int unsigned IMG_W    = REG_COUNT * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_mode,
    input  logic             cs,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             ale,
    input  logic [7:0]       addr_in,
    input  logic [7:0]       data_in,
    output logic [7:0]       data_out,
    output logic             data_oe,
    input  logic             irq_req,
    output logic             int_n,
    output logic [IMG_W-1:0] reg_image
);
    logic [3:0] strobe_s;
    logic cs_s, wr_s, rd_s, ale_s;
    logic wr_prev;
    logic [7:0] lo_q;
    logic hit;
    logic [OFF_W-1:0] off;
    logic cap_valid;
    logic [OFF_W-1:0] cap_off;
    byte_t cap_data;
    logic commit;
    byte_t rdata;

    hbus_sync #(.W(4), .STAGES(SYNC_DEPTH), .RST_VAL(4'b0110)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({ale, rd_n, wr_n, cs}),
        .q(strobe_s)
    );
    assign cs_s  = strobe_s[0];
    assign wr_s  = strobe_s[1];
    assign rd_s  = strobe_s[2];
    assign ale_s = strobe_s[3];

    // follow the shared bus while the latch strobe is high, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            lo_q <= '0;
        else if (ale_s)
            lo_q <= data_in;
    end

    hbus_decode #(.REG_COUNT(REG_COUNT), .HI_WIN(HI_WIN)) u_dec (
        .mode_sep(bus_mode), .addr_byte(addr_in), .lo_latched(lo_q),
        .hit(hit), .off(off)
    );

    // remember the last write-strobe level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_prev <= 1'b1;
        else
            wr_prev <= wr_s;
    end

    // capture address and data during the selected low phase of the write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_valid <= 1'b0;
            cap_off   <= '0;
            cap_data  <= '0;
        end else if (cs_s && !wr_s) begin
            cap_valid <= hit;
            cap_off   <= off;
            cap_data  <= data_in;
        end else if (commit || (wr_s && !wr_prev)) begin
            cap_valid <= 1'b0;
        end
    end

    assign commit = wr_s && !wr_prev && cs_s && cap_valid;

    hbus_regfile #(.REG_COUNT(REG_COUNT)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we(commit), .waddr(cap_off), .wdata(cap_data),
        .rd_hit(hit && cs_s && !rd_s), .raddr(off),
        .irq_req(irq_req),
        .rdata(rdata), .int_n(int_n), .image(reg_image)
    );

    assign data_oe  = cs && !rd_n;
    assign data_out = rdata;

    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale_s && !bus_mode) |=> $stable(lo_q));
    assert_commit_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(cs_s));
    assert_window_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> rdata == '0);
    assert_off_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> int'(off) < REG_COUNT);
endmodule

// File: tb/hbus_slave_test.sv
module hbus_slave_test;
    localparam int NREG = 77;

    logic clk = 0;
    logic rst_n = 0;
    logic bus_mode = 1;
    logic cs = 0, wr_n = 1, rd_n = 1, ale = 0;
    logic [7:0] addr_in = 0, data_in = 0;
    logic [7:0] data_out;
    logic data_oe;
    logic irq_req = 0;
    logic int_n;
    logic [NREG*8-1:0] reg_image;

    int total = 0, bad = 0;
    bit mon_on = 0, done = 0;
    logic [7:0] mdl [NREG];
    bit exp_pend = 0;

    always #2 clk = ~clk;

    hbus_slave uut (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .cs(cs), .wr_n(wr_n),
        .rd_n(rd_n), .ale(ale), .addr_in(addr_in), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .irq_req(irq_req),
        .int_n(int_n), .reg_image(reg_image)
    );

    task automatic check(bit ok, string req, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison of the line-level outputs with the model
    always @(negedge clk) begin
        if (mon_on && !done) begin
            check(data_oe == (cs && !rd_n), "R7 oe", data_oe, cs && !rd_n);
            check(int_n == !exp_pend, "R9 int_n", int_n, !exp_pend);
        end
    end

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 0;
        exp_pend = 0;
        for (int k = 0; k < NREG; k++) mdl[k] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        mon_on = 1;
    endtask

    function automatic bit in_win(logic [7:0] hi, logic [7:0] lo);
        if (bus_mode) return int'(lo) < NREG;
        return hi == 8'h80 && int'(lo) < NREG;
    endfunction

    task automatic addr_phase(logic [7:0] lo);
        @(posedge clk); #1;
        ale = 1; data_in = lo;
        repeat (4) @(posedge clk);
        #1 ale = 0;
        repeat (4) @(posedge clk);
    endtask

    // hi is ignored in mode 1; lo is addr_in in mode 1
    task automatic bus_write(logic [7:0] hi, logic [7:0] lo, logic [7:0] d, bit sel);
        if (!bus_mode) addr_phase(lo);
        @(posedge clk); #1;
        addr_in = bus_mode ? lo : hi;
        data_in = d; cs = sel; wr_n = 0;
        repeat (4) @(posedge clk);
        #1 wr_n = 1;
        repeat (3) @(posedge clk);
        #1;
        if (sel && in_win(hi, lo)) begin
            mdl[lo] = (lo == 8'h03) ? (d & 8'hDF) : d;
            if (lo == 8'h03 && d[5]) exp_pend = 0;
        end
        cs = 0;
        repeat (3) @(posedge clk);
    endtask

    task automatic bus_read(logic [7:0] hi, logic [7:0] lo, logic [7:0] exp, string req);
        if (!bus_mode) begin
            addr_phase(lo);
            data_in = lo ^ 8'h01;   // a different in-window byte on the shared bus
        end
        @(posedge clk); #1;
        addr_in = bus_mode ? lo : hi;
        cs = 1; rd_n = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(data_out == exp, req, data_out, exp);
        @(posedge clk); #1;
        rd_n = 1; cs = 0;
        repeat (3) @(posedge clk);
    endtask

    task automatic check_image(string req);
        logic [NREG*8-1:0] e;
        for (int k = 0; k < NREG; k++) e[k*8 +: 8] = mdl[k];
        @(negedge clk);
        check(reg_image == e, req, reg_image[63:0], e[63:0]);
    endtask

    task automatic pulse_irq();
        @(posedge clk); #1 irq_req = 1;
        @(posedge clk); #1 irq_req = 0;
        exp_pend = 1;
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        check(int_n == 1'b1, "R1 int_n", int_n, 1);
        check(reg_image == '0, "R1 image", reg_image[63:0], 0);
        bus_read(8'h00, 8'h10, 8'h00, "R1 read");

        // separate-bus mode
        bus_write(8'h00, 8'h10, 8'hA5, 1);
        bus_read(8'h00, 8'h10, 8'hA5, "R2 rw");
        bus_write(8'h00, 8'h00, 8'h11, 1);
        bus_write(8'h00, 8'h4C, 8'h4C, 1);
        bus_read(8'h00, 8'h00, 8'h11, "R8 low edge");
        bus_read(8'h00, 8'h4C, 8'h4C, "R8 high edge");
        bus_write(8'h00, 8'h4D, 8'h77, 1);
        bus_read(8'h00, 8'h4D, 8'h00, "R6 beyond");
        check_image("R6 image");
        bus_write(8'h00, 8'h20, 8'h99, 0);
        bus_read(8'h00, 8'h20, 8'h00, "R5 no cs");
        check_image("R11 image");
        @(posedge clk); #1 rd_n = 0;
        repeat (3) @(posedge clk);
        #1 rd_n = 1;

        // interrupt hold and clear
        pulse_irq();
        repeat (5) @(posedge clk);
        bus_write(8'h00, 8'h03, 8'h01, 1);
        bus_read(8'h00, 8'h03, 8'h01, "R10 keep");
        check(int_n == 1'b0, "R9 still low", int_n, 0);
        bus_write(8'h00, 8'h03, 8'h23, 1);
        bus_read(8'h00, 8'h03, 8'h03, "R10 action bit");
        check(int_n == 1'b1, "R9 cleared", int_n, 1);

        // multiplexed mode
        bus_mode = 0;
        do_reset();
        bus_write(8'h80, 8'h05, 8'h3C, 1);
        bus_read(8'h80, 8'h05, 8'h3C, "R3 rw");
        bus_write(8'h80, 8'h07, 8'hC3, 1);
        bus_read(8'h80, 8'h07, 8'hC3, "R4 held low byte");
        bus_read(8'h80, 8'h04, 8'h00, "R4 neighbour");
        bus_write(8'h81, 8'h05, 8'h55, 1);
        bus_read(8'h81, 8'h05, 8'h00, "R6 high byte");
        bus_read(8'h80, 8'h05, 8'h3C, "R3 untouched");
        bus_write(8'h80, 8'h4C, 8'hE1, 1);
        bus_read(8'h80, 8'h4C, 8'hE1, "R8 mode0 edge");
        check_image("R11 mode0 image");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule